// File: doc/BRIEF.md
# One-Time-Programmable Array Direct Command Front-End

This block is the software-facing side of direct access to a one-time-programmable storage array. Software loads a word address and up to two 32-bit data words into local registers. It then writes a one-hot command word that asks for a read, a program (write) or a digest-and-lock sequence. The front-end checks the command, works out from a parameter table of partitions whether the target is a 32-bit or a 64-bit location, aligns the address to that granule, and hands one request to a storage backend over a valid/ready handshake. It then waits for a single response beat.

When the response arrives, the block raises a one-cycle completion pulse and records the backend's 3-bit status code. On a successful read it also captures the returned data into two read-data registers. A sticky lock bit, which software can only clear, blocks all further changes to the command, address and write-data registers. Hardware also drops the visible lock and the idle flag for as long as a command is in flight, so that operands cannot change under a pending operation.

Top module: `dacc_frontend`

## Requirements
- R1: After reset, `idle` and `regwen` are 1. `addr`, `wdata0`, `wdata1`, `rdata0`, `rdata1` and `err_code` are 0. `op_done`, `err_pulse` and `be_req_valid` are 0.
- R2: A write with `wr_en`=1 takes effect at that clock edge only while `regwen` is 1. Register select 2 loads `addr` from `wr_data[10:0]`. Select 3 loads `wdata0` and select 4 loads `wdata1`.
- R3: A write with select 0 and `wr_data[0]`=0 clears the lock until the next reset. Writing 1 there has no effect. While the lock is clear, `regwen` is 0 and writes with selects 1 to 4 change nothing.
- R4: From the edge that accepts a command until the edge that takes its response, `idle` and `regwen` are 0 and writes with selects 1 to 4 are ignored.
- R5: A write with select 1 is a command. `wr_data` bit 0 requests a read (`be_op`=1), bit 1 a program (`be_op`=2) and bit 2 a digest (`be_op`=3). A value of 0 does nothing.
- R6: A command with more than one of bits 2:0 set, or whose address lies in no partition, starts no request. It sets `err_code` to 5 and pulses `err_pulse` for one cycle, and `idle` stays 1.
- R7: For a partition flagged 64-bit, `be_wide`=1, `be_addr` has bits 2:0 cleared and `be_wdata` is {`wdata1`,`wdata0`}. Otherwise `be_wide`=0, `be_addr` has bits 1:0 cleared and `be_wdata[63:32]` is 0.
- R8: For a digest command, `be_addr` is the base address of the partition that contains `addr`.
- R9: `be_req_valid` rises in the cycle after an accepted command and, with all request fields, holds steady until a cycle with `be_req_ready`=1.
- R10: A response taken while waiting gives `op_done`=1 for exactly one cycle after that edge, and `idle` returns to 1 in the same cycle.
- R11: A read response with status 0 loads `rdata0` from `be_rsp_rdata[31:0]`. For a 64-bit read, `rdata1` is loaded from `be_rsp_rdata[63:32]`; for a 32-bit read, `rdata1` is cleared. A response with a nonzero status leaves both unchanged.
- R12: Each taken response copies `be_rsp_err` into `err_code`, so 0 clears it. A nonzero status also pulses `err_pulse` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 lock, 1 command, 2 address, 3 data low, 4 data high |
| wr_data | input | 32 | Register write value |
| regwen | output | 1 | Visible write enable (lock and idle) |
| idle | output | 1 | No command in flight |
| addr | output | 11 | Address register |
| wdata0 | output | 32 | Write-data low word |
| wdata1 | output | 32 | Write-data high word |
| rdata0 | output | 32 | Read-data low word |
| rdata1 | output | 32 | Read-data high word |
| err_code | output | 3 | Last recorded status code |
| op_done | output | 1 | One-cycle completion pulse |
| err_pulse | output | 1 | One-cycle error pulse |
| be_req_valid | output | 1 | Backend request valid |
| be_req_ready | input | 1 | Backend request accept |
| be_op | output | 2 | Request kind: 1 read, 2 program, 3 digest |
| be_wide | output | 1 | Request uses a 64-bit granule |
| be_addr | output | 11 | Aligned request address |
| be_wdata | output | 64 | Request program data |
| be_rsp_valid | input | 1 | Backend response valid |
| be_rsp_err | input | 3 | Backend response status |
| be_rsp_rdata | input | 64 | Backend response read data |

## Verification
The assertions assume that the backend presents a response only after it has accepted a request, and never while the request is still waiting to be accepted. They also assume at most one response for each accepted request. The bench's backend responder follows this strictly: it raises ready only against a pending valid, and raises the response only after a programmable latency once it has accepted. Register writes that overlap a busy operation or a cleared lock are deliberate, because they fall inside the stimulus space the properties cover.

// File: rtl/dacc_pkg.sv
`timescale 1ns/1ps
package dacc_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_READ   = 2'd1,
    OP_WRITE  = 2'd2,
    OP_DIGEST = 2'd3
  } dacc_op_e;

  typedef enum logic [2:0] {
    SEL_LOCK = 3'd0,
    SEL_CMD  = 3'd1,
    SEL_ADDR = 3'd2,
    SEL_WD0  = 3'd3,
    SEL_WD1  = 3'd4
  } dacc_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } dacc_state_e;

  localparam int unsigned ERR_W      = 3;
  localparam int unsigned CMD_W      = 3;
  localparam logic [2:0]  ERR_NONE   = 3'd0;
  localparam logic [2:0]  ERR_ACCESS = 3'd5;
endpackage

// File: rtl/dacc_part_decode.sv
`timescale 1ns/1ps
module dacc_part_decode #(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned NUM_PART = 4,
  parameter logic [NUM_PART*ADDR_W-1:0] PART_BASE = '0,
  parameter logic [NUM_PART*ADDR_W-1:0] PART_SIZE = '0,
  parameter logic [NUM_PART-1:0]        PART_WIDE = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              wide_o,
  output logic [ADDR_W-1:0] base_o
);
  localparam int unsigned CMP_W = ADDR_W + 1;

  logic [NUM_PART-1:0] match;

  for (genvar gi = 0; gi < NUM_PART; gi++) begin : g_part
    logic [CMP_W-1:0] lo_bound;
    logic [CMP_W-1:0] hi_bound;
    assign lo_bound    = {1'b0, PART_BASE[gi*ADDR_W +: ADDR_W]};
    assign hi_bound    = lo_bound + {1'b0, PART_SIZE[gi*ADDR_W +: ADDR_W]};
    assign match[gi]   = ({1'b0, addr_i} >= lo_bound) && ({1'b0, addr_i} < hi_bound);
  end

  // lowest-numbered matching partition wins
  always_comb begin
    hit_o  = 1'b0;
    wide_o = 1'b0;
    base_o = '0;
    for (int i = NUM_PART - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o  = 1'b1;
        wide_o = PART_WIDE[i];
        base_o = PART_BASE[i*ADDR_W +: ADDR_W];
      end
    end
  end
endmodule

// File: rtl/dacc_regs.sv
`timescale 1ns/1ps
module dacc_regs
  import dacc_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              gate_open_i,
  output logic              lock_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] wd0_o,
  output logic [WORD_W-1:0] wd1_o,
  output logic              cmd_valid_o,
  output logic [CMD_W-1:0]  cmd_bits_o
);
  logic              lock_q, lock_d;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wd0_q, wd1_q;
  logic              addr_en, wd0_en, wd1_en;

  always_comb begin
    addr_en     = wr_en_i && gate_open_i && (wr_sel_i == SEL_ADDR);
    wd0_en      = wr_en_i && gate_open_i && (wr_sel_i == SEL_WD0);
    wd1_en      = wr_en_i && gate_open_i && (wr_sel_i == SEL_WD1);
    cmd_valid_o = wr_en_i && gate_open_i && (wr_sel_i == SEL_CMD);
    cmd_bits_o  = wr_data_i[CMD_W-1:0];
    lock_d      = lock_q;
    if (wr_en_i && (wr_sel_i == SEL_LOCK) && !wr_data_i[0]) begin
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
      addr_q <= '0;
      wd0_q  <= '0;
      wd1_q  <= '0;
    end else begin
      lock_q <= lock_d;
      if (addr_en) addr_q <= wr_data_i[ADDR_W-1:0];
      if (wd0_en)  wd0_q  <= wr_data_i;
      if (wd1_en)  wd1_q  <= wr_data_i;
    end
  end

  assign lock_o = lock_q;
  assign addr_o = addr_q;
  assign wd0_o  = wd0_q;
  assign wd1_o  = wd1_q;
endmodule

// File: rtl/dacc_seq.sv
`timescale 1ns/1ps
module dacc_seq
  import dacc_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid_i,
  input  logic [CMD_W-1:0]    cmd_bits_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   wd0_i,
  input  logic [WORD_W-1:0]   wd1_i,
  input  logic                part_hit_i,
  input  logic                part_wide_i,
  input  logic [ADDR_W-1:0]   part_base_i,
  input  logic                be_req_ready_i,
  input  logic                be_rsp_valid_i,
  input  logic [ERR_W-1:0]    be_rsp_err_i,
  input  logic [2*WORD_W-1:0] be_rsp_rdata_i,
  output logic                idle_o,
  output logic                be_req_valid_o,
  output logic [1:0]          be_op_o,
  output logic                be_wide_o,
  output logic [ADDR_W-1:0]   be_addr_o,
  output logic [2*WORD_W-1:0] be_wdata_o,
  output logic [WORD_W-1:0]   rd0_o,
  output logic [WORD_W-1:0]   rd1_o,
  output logic [ERR_W-1:0]    err_code_o,
  output logic                op_done_o,
  output logic                err_pulse_o
);
  localparam int unsigned DATA_W = 2 * WORD_W;

  dacc_state_e       state_q, state_d;
  dacc_op_e          op_q, op_sel;
  logic              wide_q;
  logic [ADDR_W-1:0] req_addr_q, align_addr, tgt_addr;
  logic [DATA_W-1:0] req_wdata_q, tgt_wdata;
  logic [WORD_W-1:0] rd0_q, rd1_q;
  logic [ERR_W-1:0]  err_q, err_d;
  logic              done_q, errp_q;
  logic              one_hot, accept, reject;
  logic              req_load, rsp_take, rd_load, err_load, errp_d;

  always_comb begin
    one_hot = (cmd_bits_i != '0) && ((cmd_bits_i & (cmd_bits_i - 3'd1)) == '0);
    accept  = (state_q == ST_IDLE) && cmd_valid_i && one_hot && part_hit_i;
    reject  = (state_q == ST_IDLE) && cmd_valid_i && (cmd_bits_i != '0) &&
              !(one_hot && part_hit_i);

    if (cmd_bits_i[0])      op_sel = OP_READ;
    else if (cmd_bits_i[1]) op_sel = OP_WRITE;
    else                    op_sel = OP_DIGEST;

    align_addr = part_wide_i ? {addr_i[ADDR_W-1:3], 3'b000}
                             : {addr_i[ADDR_W-1:2], 2'b00};
    tgt_addr   = (op_sel == OP_DIGEST) ? part_base_i : align_addr;
    tgt_wdata  = {(part_wide_i ? wd1_i : {WORD_W{1'b0}}), wd0_i};

    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)         state_d = ST_REQ;
      ST_REQ:  if (be_req_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (be_rsp_valid_i) state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase

    req_load = accept;
    rsp_take = (state_q == ST_WAIT) && be_rsp_valid_i;
    rd_load  = rsp_take && (be_rsp_err_i == ERR_NONE) && (op_q == OP_READ);
    err_load = rsp_take || reject;
    err_d    = reject ? ERR_ACCESS : be_rsp_err_i;
    errp_d   = reject || (rsp_take && (be_rsp_err_i != ERR_NONE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_NONE;
      wide_q      <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      rd0_q       <= '0;
      rd1_q       <= '0;
      err_q       <= ERR_NONE;
      done_q      <= 1'b0;
      errp_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= rsp_take;
      errp_q  <= errp_d;
      if (req_load) begin
        op_q        <= op_sel;
        wide_q      <= part_wide_i;
        req_addr_q  <= tgt_addr;
        req_wdata_q <= tgt_wdata;
      end
      if (rd_load) begin
        rd0_q <= be_rsp_rdata_i[WORD_W-1:0];
        rd1_q <= wide_q ? be_rsp_rdata_i[DATA_W-1:WORD_W] : {WORD_W{1'b0}};
      end
      if (err_load) err_q <= err_d;
    end
  end

  assign idle_o         = (state_q == ST_IDLE);
  assign be_req_valid_o = (state_q == ST_REQ);
  assign be_op_o        = op_q;
  assign be_wide_o      = wide_q;
  assign be_addr_o      = req_addr_q;
  assign be_wdata_o     = req_wdata_q;
  assign rd0_o          = rd0_q;
  assign rd1_o          = rd1_q;
  assign err_code_o     = err_q;
  assign op_done_o      = done_q;
  assign err_pulse_o    = errp_q;
endmodule

// File: rtl/dacc_frontend.sv
`timescale 1ns/1ps
module dacc_frontend
  import dacc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned NUM_PART = 4,
  parameter logic [NUM_PART*ADDR_W-1:0] PART_BASE = {11'h400, 11'h300, 11'h100, 11'h000},
  parameter logic [NUM_PART*ADDR_W-1:0] PART_SIZE = {11'h400, 11'h100, 11'h100, 11'h100},
  parameter logic [NUM_PART-1:0]        PART_WIDE = 4'b1100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          wr_sel,
  input  logic [WORD_W-1:0]   wr_data,
  output logic                regwen,
  output logic                idle,
  output logic [ADDR_W-1:0]   addr,
  output logic [WORD_W-1:0]   wdata0,
  output logic [WORD_W-1:0]   wdata1,
  output logic [WORD_W-1:0]   rdata0,
  output logic [WORD_W-1:0]   rdata1,
  output logic [2:0]          err_code,
  output logic                op_done,
  output logic                err_pulse,
  output logic                be_req_valid,
  input  logic                be_req_ready,
  output logic [1:0]          be_op,
  output logic                be_wide,
  output logic [ADDR_W-1:0]   be_addr,
  output logic [2*WORD_W-1:0] be_wdata,
  input  logic                be_rsp_valid,
  input  logic [2:0]          be_rsp_err,
  input  logic [2*WORD_W-1:0] be_rsp_rdata
);
  logic              lock_q;
  logic              gate_open;
  logic              cmd_valid;
  logic [CMD_W-1:0]  cmd_bits;
  logic              part_hit, part_wide;
  logic [ADDR_W-1:0] part_base;

  assign gate_open = lock_q && idle;
  assign regwen    = gate_open;

  dacc_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .wr_sel_i    (wr_sel),
    .wr_data_i   (wr_data),
    .gate_open_i (gate_open),
    .lock_o      (lock_q),
    .addr_o      (addr),
    .wd0_o       (wdata0),
    .wd1_o       (wdata1),
    .cmd_valid_o (cmd_valid),
    .cmd_bits_o  (cmd_bits)
  );

  dacc_part_decode #(
    .ADDR_W(ADDR_W), .NUM_PART(NUM_PART),
    .PART_BASE(PART_BASE), .PART_SIZE(PART_SIZE), .PART_WIDE(PART_WIDE)
  ) u_decode (
    .addr_i (addr),
    .hit_o  (part_hit),
    .wide_o (part_wide),
    .base_o (part_base)
  );

  dacc_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid_i    (cmd_valid),
    .cmd_bits_i     (cmd_bits),
    .addr_i         (addr),
    .wd0_i          (wdata0),
    .wd1_i          (wdata1),
    .part_hit_i     (part_hit),
    .part_wide_i    (part_wide),
    .part_base_i    (part_base),
    .be_req_ready_i (be_req_ready),
    .be_rsp_valid_i (be_rsp_valid),
    .be_rsp_err_i   (be_rsp_err),
    .be_rsp_rdata_i (be_rsp_rdata),
    .idle_o         (idle),
    .be_req_valid_o (be_req_valid),
    .be_op_o        (be_op),
    .be_wide_o      (be_wide),
    .be_addr_o      (be_addr),
    .be_wdata_o     (be_wdata),
    .rd0_o          (rdata0),
    .rd1_o          (rdata1),
    .err_code_o     (err_code),
    .op_done_o      (op_done),
    .err_pulse_o    (err_pulse)
  );
endmodule

// File: rtl/dacc_frontend_chk.sv
`timescale 1ns/1ps
module dacc_frontend_chk #(
  parameter int unsigned ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              idle,
  input logic              regwen,
  input logic              lock_q,
  input logic [ADDR_W-1:0] addr,
  input logic              op_done,
  input logic              be_req_valid,
  input logic              be_req_ready,
  input logic [1:0]        be_op,
  input logic              be_wide,
  input logic [ADDR_W-1:0] be_addr,
  input logic              be_rsp_valid
);
  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> !lock_q);

  p_closed_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !regwen |=> $stable(addr));

  p_busy_hides_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> !regwen);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    be_req_valid && !be_req_ready |=> be_req_valid && $stable(be_addr) && $stable(be_op));

  p_wide_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    be_req_valid && be_wide |-> be_addr[2:0] == 3'b000);

  p_narrow_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    be_req_valid |-> be_addr[1:0] == 2'b00);

  p_done_follows_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    be_rsp_valid && !idle && !be_req_valid |=> op_done && idle);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);
endmodule

bind dacc_frontend dacc_frontend_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .idle         (idle),
  .regwen       (regwen),
  .lock_q       (lock_q),
  .addr         (addr),
  .op_done      (op_done),
  .be_req_valid (be_req_valid),
  .be_req_ready (be_req_ready),
  .be_op        (be_op),
  .be_wide      (be_wide),
  .be_addr      (be_addr),
  .be_rsp_valid (be_rsp_valid)
);

// File: tb/tb_dacc_frontend.sv
`timescale 1ns/1ps
module tb_dacc_frontend;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic        regwen, idle;
  logic [10:0] addr;
  logic [31:0] wdata0, wdata1, rdata0, rdata1;
  logic [2:0]  err_code;
  logic        op_done, err_pulse;
  logic        be_req_valid, be_req_ready;
  logic [1:0]  be_op;
  logic        be_wide;
  logic [10:0] be_addr;
  logic [63:0] be_wdata;
  logic        be_rsp_valid;
  logic [2:0]  be_rsp_err;
  logic [63:0] be_rsp_rdata;

  dacc_frontend dut (.*);

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- backend responder ----------------
  int cfg_stall = 0, cfg_lat = 0, cfg_err = 0;
  int stall_cnt = 0, lat_cnt = 0;
  bit pend = 0;
  int last_op = 0, last_addr = 0, last_wide = 0;
  logic [63:0] last_wdata = 0;
  int req_count = 0;

  initial begin
    be_req_ready = 0; be_rsp_valid = 0; be_rsp_err = 0; be_rsp_rdata = 0;
    forever begin
      @(negedge clk);
      be_req_ready = 0;
      be_rsp_valid = 0;
      if (!rst_n) begin
        pend = 0; stall_cnt = 0;
      end else if (pend) begin
        if (lat_cnt < cfg_lat) lat_cnt++;
        else begin
          be_rsp_valid = 1;
          be_rsp_err   = 3'(cfg_err);
          be_rsp_rdata = {32'hA500_0000 | 32'(last_addr), 32'h5A00_0000 | 32'(last_addr)};
          pend = 0;
        end
      end else if (be_req_valid) begin
        if (stall_cnt < cfg_stall) stall_cnt++;
        else begin
          be_req_ready = 1; stall_cnt = 0; pend = 1; lat_cnt = 0;
          last_op = be_op; last_addr = be_addr; last_wide = be_wide;
          last_wdata = be_wdata; req_count++;
        end
      end
    end
  end

  // ---------------- reference model ----------------
  function automatic void lookup(input int a, output bit h, output bit w, output int b);
    h = 0; w = 0; b = 0;
    if (a < 'h100)                     begin h = 1; b = 'h000; end
    else if (a < 'h200)                begin h = 1; b = 'h100; end
    else if (a >= 'h300 && a < 'h400)  begin h = 1; w = 1; b = 'h300; end
    else if (a >= 'h400 && a < 'h800)  begin h = 1; w = 1; b = 'h400; end
  endfunction

  int m_state, m_addr, m_err, m_op, m_raddr;
  bit m_lock, m_done, m_errp, m_wide;
  logic [31:0] m_wd0, m_wd1, m_rd0, m_rd1;
  logic [63:0] m_rwdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_lock = 1; m_addr = 0; m_wd0 = 0; m_wd1 = 0; m_rd0 = 0; m_rd1 = 0;
      m_err = 0; m_done = 0; m_errp = 0; m_op = 0; m_raddr = 0; m_wide = 0; m_rwdata = 0;
    end else begin
      bit vis, h, w;
      int b, c, ns;
      vis = m_lock && (m_state == 0);
      ns = m_state;
      m_done = 0; m_errp = 0;
      case (m_state)
        0: if (vis && wr_en && wr_sel == 1) begin
             c = int'(wr_data[2:0]);
             lookup(m_addr, h, w, b);
             if (c != 0) begin
               if ((c == 1 || c == 2 || c == 4) && h) begin
                 m_op = (c == 1) ? 1 : (c == 2) ? 2 : 3;
                 m_wide = w;
                 m_raddr = (m_op == 3) ? b : (w ? (m_addr & 'h7F8) : (m_addr & 'h7FC));
                 m_rwdata = {w ? m_wd1 : 32'h0, m_wd0};
                 ns = 1;
               end else begin
                 m_err = 5; m_errp = 1;
               end
             end
           end
        1: if (be_req_ready) ns = 2;
        2: if (be_rsp_valid) begin
             m_done = 1;
             m_err = int'(be_rsp_err);
             m_errp = (be_rsp_err != 0);
             if (be_rsp_err == 0 && m_op == 1) begin
               m_rd0 = be_rsp_rdata[31:0];
               m_rd1 = m_wide ? be_rsp_rdata[63:32] : 32'h0;
             end
             ns = 0;
           end
        default: ns = 0;
      endcase
      if (vis && wr_en && wr_sel == 2) m_addr = int'(wr_data[10:0]);
      if (vis && wr_en && wr_sel == 3) m_wd0 = wr_data;
      if (vis && wr_en && wr_sel == 4) m_wd1 = wr_data;
      if (wr_en && wr_sel == 0 && !wr_data[0]) m_lock = 0;
      m_state = ns;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk("R4 idle", idle, m_state == 0);
      chk("R3 R4 regwen", regwen, m_lock && m_state == 0);
      chk("R2 addr", addr, m_addr);
      chk("R2 wdata0", wdata0, m_wd0);
      chk("R2 wdata1", wdata1, m_wd1);
      chk("R11 rdata0", rdata0, m_rd0);
      chk("R11 rdata1", rdata1, m_rd1);
      chk("R12 err_code", err_code, m_err);
      chk("R12 err_pulse", err_pulse, m_errp);
      chk("R10 op_done", op_done, m_done);
      chk("R9 be_req_valid", be_req_valid, m_state == 1);
      if (m_state == 1) begin
        chk("R5 be_op", be_op, m_op);
        chk("R7 be_addr", be_addr, m_raddr);
        chk("R7 be_wide", be_wide, m_wide);
        chk("R7 be_wdata", be_wdata, m_rwdata);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic reg_write(input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = 3'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!idle && n < 200) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  task automatic run_cmd(input int a, input int c);
    reg_write(2, 32'(a));
    reg_write(1, 32'(c));
    wait_idle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rc;
    wr_en = 0; wr_sel = 0; wr_data = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 idle", idle, 1); chk("R1 regwen", regwen, 1);
    chk("R1 addr", addr, 0); chk("R1 rdata0", rdata0, 0);
    chk("R1 err_code", err_code, 0); chk("R1 req_valid", be_req_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // narrow program, stalled accept
    cfg_stall = 1; cfg_lat = 2; cfg_err = 0;
    reg_write(3, 32'h1111_1111);
    reg_write(4, 32'h2222_2222);
    run_cmd('h0FF, 2);
    chk("R7 narrow align", last_addr, 'h0FC);
    chk("R7 narrow upper data", last_wdata, {32'h0, 32'h1111_1111});
    chk("R5 write op", last_op, 2);

    // narrow read
    cfg_stall = 0; cfg_lat = 0;
    run_cmd('h013, 1);
    chk("R11 narrow rdata0", rdata0, 32'h5A00_0010);
    chk("R11 narrow rdata1", rdata1, 0);

    // wide read
    run_cmd('h30D, 1);
    chk("R7 wide align", last_addr, 'h308);
    chk("R11 wide rdata1", rdata1, 32'hA500_0308);

    // wide program at top of array
    run_cmd('h7FF, 2);
    chk("R7 wide data", last_wdata, {32'h2222_2222, 32'h1111_1111});

    // digest uses partition base
    run_cmd('h345, 4);
    chk("R8 digest base", last_addr, 'h300);
    chk("R5 digest op", last_op, 3);

    // failing read leaves data
    cfg_err = 2;
    run_cmd('h020, 1);
    chk("R11 rdata kept", rdata0, 32'h5A00_0308);
    chk("R12 err forwarded", err_code, 2);
    cfg_err = 0;
    run_cmd('h020, 1);
    chk("R12 err cleared", err_code, 0);

    // rejections
    rc = req_count;
    run_cmd('h020, 3);
    chk("R6 multi-bit err", err_code, 5);
    run_cmd('h250, 1);
    chk("R6 gap err", err_code, 5);
    run_cmd('h250, 0);
    chk("R6 R5 no request", req_count, rc);

    // writes while busy are ignored
    cfg_lat = 6;
    reg_write(2, 32'h404);
    reg_write(1, 32'h1);
    reg_write(2, 32'h111);
    reg_write(3, 32'hDEAD_BEEF);
    wait_idle();
    chk("R4 busy addr kept", addr, 'h404);
    chk("R4 busy data kept", wdata0, 32'h1111_1111);
    cfg_lat = 0;

    // lock
    reg_write(0, 32'h0);
    reg_write(0, 32'h1);
    chk("R3 lock stays clear", regwen, 0);
    rc = req_count;
    reg_write(2, 32'h010);
    reg_write(1, 32'h1);
    repeat (4) @(negedge clk);
    chk("R3 locked addr", addr, 'h404);
    chk("R3 locked cmd", req_count, rc);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule